// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. On each start request it sends one word and receives one word. A 16-bit mode word supplies all the settings: an enable bit, a transfer length, the idle level of the serial clock, the clock phase, and an 8-bit divisor. The divisor sets the serial clock from the system clock. The engine drives the word out on MOSI with the most significant bit first and captures MISO at the same time. When the transfer ends it raises a one-cycle completion pulse, and the received word is valid at that moment.

The surrounding logic supplies the data word and the mode word, and it waits for busy to fall before the next request. Any setting that cannot run is rejected at the start request. A rejected request raises an error flag for one cycle and does not start a transfer. Chip selects, queue storage and register access are all outside this block.

Top module: `spi_shift_master`

## Requirements
- R1: Mode word fields: bit 15 is the enable bit, bit 14 must be zero, bits 13:10 hold the length code, bit 9 is the clock idle level, bit 8 is the phase, and bits 7:0 hold the divisor D.
- R2: A start request made while the enable bit is 0 never starts a transfer.
- R3: An idle start request is rejected when any of these holds: the enable bit is 0, bit 14 is 1, D is 0 or 1, or the length code is 0001 through 0111. A rejected request sets start_err high for exactly the next cycle, and busy stays low. A start request made while busy is ignored and does not raise start_err.
- R4: While idle, sclk equals mode bit 9. During a transfer, sclk rests at the latched bit-9 level before the first edge and returns to that level after the last edge.
- R5: With phase 0, MOSI carries the first bit from the accepting edge onward. MISO is sampled on odd-numbered clock edges (1st, 3rd, ...) and MOSI changes on even-numbered edges. With phase 1, MOSI changes on edges 3, 5, ... and MISO is sampled on edges 2, 4, ....
- R6: Each sclk half-period lasts D system cycles. The first sclk edge occurs D cycles after the accepting clock edge.
- R7: Length code 0000 selects 16 bits, and code 1xyz selects 8 + xyz bits. Data moves most significant bit first. tx_word is right-justified, and rx_word is right-justified with its unused upper bits at zero.
- R8: The settings are latched when a request is accepted. A change to the mode word during a transfer has no effect on that transfer.
- R9: busy stays high for (2N + phase) × D cycles after acceptance, where N is the number of bits. done then pulses for one cycle, and rx_word holds its value until the next done.
- R10: mosi is 0 whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_word | input | 16 | Mode settings (R1 layout) |
| start | input | 1 | Start request, one cycle |
| tx_word | input | 16 | Right-justified word to send |
| miso | input | 1 | Serial input from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 16 | Right-justified received word |
| start_err | output | 1 | One-cycle flag for a rejected start |

## Verification
A half-period counter that drifts by even one count moves the next sclk toggle. The bench compares every cycle against the latched divisor, so such a fault shows up within one half-period. A wrong edge count or a wrong sample-or-shift choice shows up on MOSI within one bit time, or it shows up as a changed rx_word and a done pulse that arrives early or late at the end of the word. Errors in settings or latching appear at the very next start, either as a falsely raised start_err or as busy rising when it should not.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int WORD_W = 16;
  localparam int NB_W   = 5;
  localparam int DIV_W  = 8;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic [DIV_W-1:0] div;
    logic [NB_W-1:0]  nbits;
  } xfer_cfg_t;

  // Length code to bit count; zero marks a reserved code.
  function automatic logic [NB_W-1:0] nbits_of(input logic [3:0] code);
    if (code == 4'b0000) return NB_W'(16);
    else if (code[3])    return {2'b01, code[2:0]};
    else                 return '0;
  endfunction

  function automatic logic start_ok(input logic [WORD_W-1:0] m);
    return m[15] && !m[14] && (m[7:0] >= 8'd2) && (nbits_of(m[13:10]) != '0);
  endfunction

  function automatic xfer_cfg_t cfg_of(input logic [WORD_W-1:0] m);
    xfer_cfg_t c;
    c.cpol  = m[9];
    c.cpha  = m[8];
    c.div   = m[7:0];
    c.nbits = nbits_of(m[13:10]);
    return c;
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cyc_q;

  assign tick = run && (cyc_q == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (!run || tick) cyc_q <= '0;
    else                   cyc_q <= cyc_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq #(
  parameter int WORD_W = 16,
  parameter int NB_W   = 5,
  parameter int HC_W   = $clog2(2 * WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              cpha,
  input  logic [NB_W-1:0]   nbits,
  input  logic              tick,
  input  logic              miso,
  output logic              mosi_bit,
  output logic              ph,
  output logic [WORD_W-1:0] rx_bits,
  output logic              edge_ev,
  output logic              samp_ev,
  output logic              shft_ev,
  output logic              fin_ev
);
  logic [HC_W-1:0]   hcnt_q;
  logic [WORD_W-1:0] sr_q;
  logic [HC_W-1:0]   n_edges;
  logic [HC_W-1:0]   last_half;
  logic              lead;

  assign n_edges   = HC_W'(nbits) << 1;
  assign last_half = n_edges + HC_W'(cpha) - HC_W'(1);
  assign lead      = !hcnt_q[0];
  assign edge_ev   = tick && (hcnt_q < n_edges);
  assign samp_ev   = edge_ev && (cpha ? !lead : lead);
  assign shft_ev   = edge_ev && (cpha ? (lead && hcnt_q != '0)
                                      : (!lead && hcnt_q != n_edges - HC_W'(1)));
  assign fin_ev    = tick && (hcnt_q == last_half);
  assign mosi_bit  = sr_q[WORD_W-1];
  assign rx_bits   = sr_rx_q;

  logic [WORD_W-1:0] sr_rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      ph      <= 1'b0;
      sr_q    <= '0;
      sr_rx_q <= '0;
    end else if (load) begin
      hcnt_q  <= '0;
      ph      <= 1'b0;
      sr_q    <= tx_word << (WORD_W - int'(nbits));
      sr_rx_q <= '0;
    end else if (tick) begin
      hcnt_q <= hcnt_q + HC_W'(1);
      if (edge_ev) ph <= !ph;
      if (shft_ev) sr_q <= sr_q << 1;
      if (samp_ev) sr_rx_q <= {sr_rx_q[WORD_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mode_word,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              start_err
);
  xfer_cfg_t         cfg_q, cfg_use;
  logic              accept, reject;
  logic              tick, ph, mosi_bit;
  logic              edge_ev, samp_ev, shft_ev, fin_ev;
  logic [WORD_W-1:0] rx_bits;

  assign accept  = start && !busy &&  start_ok(mode_word);
  assign reject  = start && !busy && !start_ok(mode_word);
  assign cfg_use = accept ? cfg_of(mode_word) : cfg_q;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_q.div), .tick(tick)
  );

  spi_edge_seq #(.WORD_W(WORD_W), .NB_W(NB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_word(tx_word),
    .cpha(cfg_use.cpha), .nbits(cfg_use.nbits), .tick(tick), .miso(miso),
    .mosi_bit(mosi_bit), .ph(ph), .rx_bits(rx_bits),
    .edge_ev(edge_ev), .samp_ev(samp_ev), .shft_ev(shft_ev), .fin_ev(fin_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rx_word   <= '0;
      start_err <= 1'b0;
    end else begin
      done      <= fin_ev;
      start_err <= reject;
      if (accept) begin
        cfg_q <= cfg_of(mode_word);
        busy  <= 1'b1;
      end else if (fin_ev) begin
        busy <= 1'b0;
      end
      if (fin_ev) rx_word <= rx_bits;
    end
  end

  assign sclk = busy ? (cfg_q.cpol ^ ph) : mode_word[9];
  assign mosi = busy && mosi_bit;
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk
  import spi_eng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] mode_word,
  input logic              busy,
  input logic              done,
  input logic              start_err,
  input logic [WORD_W-1:0] rx_word,
  input logic              mosi,
  input logic              ph,
  input logic              samp_ev,
  input logic              edge_ev,
  input xfer_cfg_t         cfg_q
);
  p_err_no_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !busy);
  p_enable_needed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_word[15]));
  p_div_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(mode_word[7:0]) >= 8'd2));
  p_clock_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ph);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));
  p_rx_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rx_word >> cfg_q.nbits) == '0));
  p_sample_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ev || edge_ev) |-> busy);
  p_mosi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);
endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .busy(busy), .done(done),
  .start_err(start_err), .rx_word(rx_word), .mosi(mosi), .ph(ph),
  .samp_ev(samp_ev), .edge_ev(edge_ev), .cfg_q(cfg_q)
);

// File: tb/spi_shift_master_test.sv
`timescale 1ns/1ps
module spi_shift_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mode_word = 16'h0;
  logic        start = 1'b0;
  logic [15:0] tx_word = 16'h0;
  logic        miso = 1'b0;
  logic        sclk, mosi, busy, done, start_err;
  logic [15:0] rx_word;

  int checks = 0;
  int errors = 0;
  bit ended = 0;
  string scen = "reset R10";
  logic [15:0] pat = 16'h0;

  // reference model state
  bit          m_act = 0;
  int          m_c = 0, m_n = 0, m_d = 0, m_total = 0;
  bit          m_cpol = 0, m_cpha = 0, m_done = 0, m_err = 0;
  logic [15:0] m_tx = 0, m_pat = 0, m_rx = 0;

  always #4 clk = !clk;

  spi_shift_master uut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
    .tx_word(tx_word), .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
    .done(done), .rx_word(rx_word), .start_err(start_err)
  );

  function automatic int len_code(input logic [3:0] c);
    if (c == 0) return 16;
    if (c >= 8) return c;
    return 0;
  endfunction

  function automatic int edges_now();
    int e;
    if (!m_act) return 0;
    e = m_c / m_d;
    return (e > 2 * m_n) ? 2 * m_n : e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_err = 0; m_rx = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_act) begin
        m_c++;
        if (m_c == m_total) begin
          m_act = 0; m_done = 1;
          m_rx = m_pat & 16'((32'd1 << m_n) - 1);
        end
      end else if (start) begin
        int n, d;
        n = len_code(mode_word[13:10]);
        d = mode_word[7:0];
        if (mode_word[15] && !mode_word[14] && d >= 2 && n != 0) begin
          m_act = 1; m_c = 0; m_n = n; m_d = d;
          m_cpol = mode_word[9]; m_cpha = mode_word[8];
          m_total = (2 * n + (mode_word[8] ? 1 : 0)) * d;
          m_tx = tx_word; m_pat = pat;
        end else m_err = 1;
      end
    end
  end

  // slave side: present the next pattern bit before each sampling edge
  always @(negedge clk) begin
    int e, j;
    e = edges_now();
    j = m_cpha ? e / 2 : (e + 1) / 2;
    miso <= (m_act && j < m_n) ? m_pat[m_n - 1 - j] : 1'b0;
  end

  task automatic chk(input bit ok, input string what, input int a, input int x);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", what, scen, a, x, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !ended) begin
      int e, s;
      bit xs, xm;
      e = edges_now();
      xs = m_act ? (m_cpol ^ e[0]) : mode_word[9];
      if (m_cpha) s = (e >= 1) ? (e - 1) / 2 : 0;
      else        s = e / 2;
      if (s > m_n - 1) s = m_n - 1;
      xm = m_act ? m_tx[m_n - 1 - s] : 1'b0;
      chk(sclk === xs, "sclk R4 R5 R6", sclk, xs);
      chk(mosi === xm, "mosi R5 R7 R10", mosi, xm);
      chk(busy === m_act, "busy R9", busy, m_act);
      chk(done === m_done, "done R9", done, m_done);
      chk(rx_word === m_rx, "rx_word R7 R9", rx_word, m_rx);
      chk(start_err === m_err, "start_err R3", start_err, m_err);
    end
  end

  task automatic pulse(input logic [15:0] m, input logic [15:0] tx, input logic [15:0] p);
    @(negedge clk);
    mode_word = m; tx_word = tx; pat = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (m_act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input string tag, input logic [15:0] m,
                      input logic [15:0] tx, input logic [15:0] p);
    scen = tag;
    pulse(m, tx, p);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: 8 bits (code 1000), idle low, phase 0, D=2
    xfer("R1", 16'b1_0_1000_0_0_00000010, 16'h00A5, 16'h003C);
    // R5: 16 bits, idle high, phase 1, D=3
    xfer("R5", 16'b1_0_0000_1_1_00000011, 16'h1234, 16'hBEEF);
    // R7: 11 bits, idle low, phase 1, D=2
    xfer("R7", 16'b1_0_1011_0_1_00000010, 16'h0555, 16'h06A3);
    // R4: 15 bits, idle high, phase 0, D=4
    xfer("R4", 16'b1_0_1111_1_0_00000100, 16'h7F01, 16'h4321);
    // R6: long divisor
    xfer("R6", 16'b1_0_1000_0_0_11111111, 16'h0081, 16'h00C3);
    // R2: enable bit clear
    xfer("R2", 16'b0_0_1000_0_0_00000010, 16'h00FF, 16'h0000);
    // R3: divisor zero, divisor one, reserved code, reserved bit set
    xfer("R3", 16'b1_0_1000_0_0_00000000, 16'h00FF, 16'h0000);
    xfer("R3", 16'b1_0_1000_0_0_00000001, 16'h00FF, 16'h0000);
    xfer("R3", 16'b1_0_0011_0_0_00000010, 16'h00FF, 16'h0000);
    xfer("R3", 16'b1_1_1000_0_0_00000010, 16'h00FF, 16'h0000);
    // R8: mode and a second start change during a transfer
    scen = "R8";
    pulse(16'b1_0_1001_0_0_00000010, 16'h01A7, 16'h0155);
    repeat (5) @(negedge clk);
    mode_word = 16'b1_0_0000_0_1_00000011;
    tx_word = 16'hFFFF; pat = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode_word = 16'b1_0_1100_1_1_00000101;
    wait_idle();
    // back-to-back after completion, phase 1 idle high, 9 bits
    xfer("R9", 16'b1_0_1001_1_1_00000010, 16'h0100, 16'h01FF);
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule